// File: doc/BRIEF.md
# Sliding-Window LZSS Stream Decompressor

This block turns a compressed byte stream into the original data. The compressed stream arrives on a byte-wide valid/ready input whose final byte carries a last marker. A 14-byte header comes first, and its leading eight bytes must spell a fixed signature. After the header, control bytes choose, one bit per item, between a literal byte and a two-byte back-reference. A back-reference copies 2 to 17 bytes out of a 4096-byte history window.

Each decoded byte is written into the history window and packed into 32-bit words on a valid/ready output. When a stream ends, the block waits until its last word has been accepted. It then gives a one-cycle completion pulse carrying the number of bytes produced and an error flag. After that it clears the window again and is ready for the next stream.

Top module: `lzss_window_decoder`

## Requirements
- R1: After reset, and again after every completion pulse, the block clears window locations 0x000..0xFED. This takes one location per cycle, so `in_ready` stays low for 4078 cycles, and a reference into untouched locations yields zero bytes.
- R2: Each control byte covers up to eight following items, taken from bit 0 to bit 7. A 1 bit means one literal byte follows, and the literal is output unchanged. A 0 bit means a two-byte reference follows.
- R3: In a reference, the first byte gives offset bits [7:0]. The upper nibble of the second byte gives offset bits [11:8]. The lower nibble of the second byte plus 2 gives the length, so a nibble of 0xF copies 17 bytes.
- R4: Every output byte is written into the window at the write pointer, which starts at 0xFEE and advances by one modulo 4096 per byte. A later reference to that location returns the byte.
- R5: A copy may read locations that the same copy has just written, so a reference at distance one repeats a single byte.
- R6: During a copy, the read offset advances by one modulo 4096 per byte, wrapping from 0xFFF to 0x000.
- R7: If the stream ends after a control byte, after any complete item, or after only the first byte of a reference, decoding stops cleanly. No partial reference is output.
- R8: Output words are little-endian, with the first byte in bits [7:0]. `out_nbytes` gives the number of valid bytes (1..4). The final word may be partial, and its unused upper bytes are zero.
- R9: If any of the first eight header bytes differs from "SLIDE4K" followed by 0x00, or the stream ends inside the 14-byte header, the rest of the stream is consumed without output. The completion pulse then reports an error and a count of zero.
- R10: Stalls on the output hold the output word stable and pause parsing and copying, with no byte lost or duplicated.
- R11: `done` pulses for one cycle after the last word has been accepted. `done_bytes` then gives the total number of bytes output for the stream, and no word is pending during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| in_data | input | 8 | Compressed stream byte |
| in_last | input | 1 | Marks the final byte of a stream |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output consumer ready |
| out_data | output | 32 | Packed output bytes, little-endian |
| out_nbytes | output | 3 | Valid bytes in `out_data` (1..4) |
| done | output | 1 | One-cycle end-of-stream pulse |
| done_bytes | output | CNT_W | Bytes output for the finished stream |
| done_err | output | 1 | Header failure for the finished stream |

## Verification
The hardest case to reach from the ports is a copy that reads across the window's end while it reads bytes it has itself just written. Reaching it needs the write pointer at 0x000, which only happens after exactly 18 output bytes. The stimulus therefore sends two full literal groups, then two more literals, then a reference at 0xFFE of length four. The result must repeat the last two literals twice. The same streams are replayed with output stalls and input gaps, so that a copy pauses in the middle while a word is pending.

// File: rtl/lzss_pkg.sv
package lzss_pkg;

    localparam int WIN_AW     = 12;
    localparam int WIN_DEPTH  = 1 << WIN_AW;
    localparam int MIN_MATCH  = 2;
    localparam int MAX_MATCH  = 15 + MIN_MATCH;
    localparam int PREFILL_N  = WIN_DEPTH - (MAX_MATCH + 1);
    localparam logic [WIN_AW-1:0] PREFILL_END = WIN_AW'(PREFILL_N - 1);
    localparam logic [WIN_AW-1:0] WPOS_START  = WIN_AW'(PREFILL_N);
    localparam int HDR_LEN    = 14;
    localparam int SIG_LEN    = 8;
    localparam logic [8*SIG_LEN-1:0] SIG_TEXT = {"SLIDE4K", 8'h00};

    typedef enum logic [3:0] {
        ST_PREFILL, ST_HDR, ST_DRAIN, ST_FLAG, ST_LIT,
        ST_REF_LO, ST_REF_HI, ST_CP_RD, ST_CP_WR, ST_FLUSH, ST_DONE
    } dec_state_e;

    typedef struct packed {
        logic [WIN_AW-1:0] src;
        logic [4:0]        left;
    } copy_job_t;

    function automatic logic [7:0] sig_byte(input logic [2:0] idx);
        return SIG_TEXT[8*SIG_LEN-1 - 8*idx -: 8];
    endfunction

    function automatic copy_job_t make_job(input logic [7:0] lo, input logic [7:0] hi);
        copy_job_t j;
        j.src  = {hi[7:4], lo};
        j.left = {1'b0, hi[3:0]} + 5'(MIN_MATCH);
        return j;
    endfunction

endpackage

// File: rtl/lzss_window_ram.sv
module lzss_window_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/lzss_word_packer.sv
module lzss_word_packer #(
    parameter int BW    = 8,
    parameter int LANES = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              byte_valid,
    input  logic [BW-1:0]                     byte_data,
    output logic                              byte_ready,
    input  logic                              flush,
    output logic                              idle,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic [BW*LANES-1:0]               out_data,
    output logic [$clog2(LANES+1)-1:0]        out_nbytes
);
    localparam int WW   = BW * LANES;
    localparam int NB_W = $clog2(LANES + 1);

    logic [WW-1:0]   acc;
    logic [NB_W-1:0] fill;

    assign byte_ready = !out_valid;
    assign idle       = !out_valid && (fill == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            fill       <= '0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_nbytes <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (byte_valid && byte_ready) begin
                if (fill == NB_W'(LANES - 1)) begin
                    out_data   <= acc | (WW'(byte_data) << (BW * (LANES - 1)));
                    out_nbytes <= NB_W'(LANES);
                    out_valid  <= 1'b1;
                    acc        <= '0;
                    fill       <= '0;
                end else begin
                    acc[fill*BW +: BW] <= byte_data;
                    fill               <= fill + 1'b1;
                end
            end else if (flush && !out_valid && fill != '0) begin
                out_data   <= acc;
                out_nbytes <= fill;
                out_valid  <= 1'b1;
                acc        <= '0;
                fill       <= '0;
            end
        end
    end
endmodule

// File: rtl/lzss_parser.sv
module lzss_parser
    import lzss_pkg::*;
#(
    parameter bit HDR_CHECK = 1'b1,
    parameter int CNT_W     = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              win_we,
    output logic [WIN_AW-1:0] win_waddr,
    output logic [7:0]        win_wdata,
    output logic              win_re,
    output logic [WIN_AW-1:0] win_raddr,
    input  logic [7:0]        win_rdata,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              byte_ready,
    output logic              flush,
    input  logic              pack_idle,
    output logic              done,
    output logic [CNT_W-1:0]  done_bytes,
    output logic              done_err
);
    dec_state_e        st;
    dec_state_e        nxt_item;
    logic [WIN_AW-1:0] pf_cnt, wpos;
    logic [7:0]        flags, ref_lo;
    logic [2:0]        bitn;
    copy_job_t         job;
    logic              tail_last, hdr_bad, err, hdr_mis, bad_now, take, emit;
    logic [3:0]        hdr_idx;
    logic [CNT_W-1:0]  nbytes;

    always_comb begin
        unique case (st)
            ST_HDR, ST_DRAIN, ST_FLAG, ST_REF_LO, ST_REF_HI: in_ready = 1'b1;
            ST_LIT:                                          in_ready = byte_ready;
            default:                                         in_ready = 1'b0;
        endcase
        take       = in_valid && in_ready;
        byte_valid = (st == ST_LIT && in_valid) || st == ST_CP_WR;
        byte_data  = (st == ST_LIT) ? in_data : win_rdata;
        emit       = byte_valid && byte_ready;
        win_we     = (st == ST_PREFILL) || emit;
        win_waddr  = (st == ST_PREFILL) ? pf_cnt : wpos;
        win_wdata  = (st == ST_PREFILL) ? 8'h00 : byte_data;
        win_re     = (st == ST_CP_RD);
        win_raddr  = job.src;
        nxt_item   = (bitn == 3'd7) ? ST_FLAG :
                     (flags[bitn + 3'd1] ? ST_LIT : ST_REF_LO);
        hdr_mis    = (hdr_idx < 4'(SIG_LEN)) && (in_data != sig_byte(hdr_idx[2:0]));
        bad_now    = hdr_bad || hdr_mis;
        flush      = (st == ST_FLUSH);
        done       = (st == ST_DONE);
        done_bytes = nbytes;
        done_err   = err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PREFILL;
            pf_cnt    <= '0;
            wpos      <= WPOS_START;
            flags     <= '0;
            ref_lo    <= '0;
            bitn      <= '0;
            job       <= '0;
            tail_last <= 1'b0;
            hdr_idx   <= '0;
            hdr_bad   <= 1'b0;
            err       <= 1'b0;
            nbytes    <= '0;
        end else begin
            if (emit) begin
                wpos   <= wpos + 1'b1;
                nbytes <= nbytes + 1'b1;
            end
            unique case (st)
                ST_PREFILL: begin
                    pf_cnt <= pf_cnt + 1'b1;
                    if (pf_cnt == PREFILL_END) begin
                        pf_cnt  <= '0;
                        wpos    <= WPOS_START;
                        nbytes  <= '0;
                        err     <= 1'b0;
                        hdr_idx <= '0;
                        hdr_bad <= 1'b0;
                        st      <= HDR_CHECK ? ST_HDR : ST_FLAG;
                    end
                end
                ST_HDR: if (take) begin
                    hdr_idx <= hdr_idx + 1'b1;
                    hdr_bad <= bad_now;
                    if (in_last) begin
                        err <= bad_now || (hdr_idx != 4'(HDR_LEN - 1));
                        st  <= ST_FLUSH;
                    end else if (hdr_idx == 4'(HDR_LEN - 1)) begin
                        err <= bad_now;
                        st  <= bad_now ? ST_DRAIN : ST_FLAG;
                    end
                end
                ST_DRAIN: if (take && in_last) st <= ST_FLUSH;
                ST_FLAG: if (take) begin
                    flags <= in_data;
                    bitn  <= '0;
                    st    <= in_last ? ST_FLUSH : (in_data[0] ? ST_LIT : ST_REF_LO);
                end
                ST_LIT: if (take) begin
                    bitn <= bitn + 1'b1;
                    st   <= in_last ? ST_FLUSH : nxt_item;
                end
                ST_REF_LO: if (take) begin
                    ref_lo <= in_data;
                    st     <= in_last ? ST_FLUSH : ST_REF_HI;
                end
                ST_REF_HI: if (take) begin
                    job       <= make_job(ref_lo, in_data);
                    tail_last <= in_last;
                    st        <= ST_CP_RD;
                end
                ST_CP_RD: st <= ST_CP_WR;
                ST_CP_WR: if (emit) begin
                    job.src  <= job.src + 1'b1;
                    job.left <= job.left - 1'b1;
                    if (job.left == 5'd1) begin
                        bitn <= bitn + 1'b1;
                        st   <= tail_last ? ST_FLUSH : nxt_item;
                    end else begin
                        st <= ST_CP_RD;
                    end
                end
                ST_FLUSH: if (pack_idle) st <= ST_DONE;
                ST_DONE:  st <= ST_PREFILL;
                default:  st <= ST_PREFILL;
            endcase
        end
    end
endmodule

// File: rtl/lzss_window_decoder.sv
module lzss_window_decoder
    import lzss_pkg::*;
#(
    parameter bit HDR_CHECK = 1'b1,
    parameter int CNT_W     = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic [2:0]       out_nbytes,
    output logic             done,
    output logic [CNT_W-1:0] done_bytes,
    output logic             done_err
);
    logic              win_we, win_re;
    logic [WIN_AW-1:0] win_waddr, win_raddr;
    logic [7:0]        win_wdata, win_rdata;
    logic              byte_valid, byte_ready, flush, pack_idle;
    logic [7:0]        byte_data;

    lzss_window_ram #(.AW(WIN_AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (win_we),
        .waddr (win_waddr),
        .wdata (win_wdata),
        .re    (win_re),
        .raddr (win_raddr),
        .rdata (win_rdata)
    );

    lzss_parser #(.HDR_CHECK(HDR_CHECK), .CNT_W(CNT_W)) u_parser (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .win_we     (win_we),
        .win_waddr  (win_waddr),
        .win_wdata  (win_wdata),
        .win_re     (win_re),
        .win_raddr  (win_raddr),
        .win_rdata  (win_rdata),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .flush      (flush),
        .pack_idle  (pack_idle),
        .done       (done),
        .done_bytes (done_bytes),
        .done_err   (done_err)
    );

    lzss_word_packer #(.BW(8), .LANES(4)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .flush      (flush),
        .idle       (pack_idle),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_nbytes (out_nbytes)
    );
endmodule

// File: rtl/lzss_decoder_chk.sv
module lzss_decoder_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input logic [2:0]       out_nbytes,
    input logic             done,
    input logic [CNT_W-1:0] done_bytes,
    input logic             done_err
);
    logic [31:0] keep_mask;

    always_comb begin
        keep_mask = (out_nbytes >= 3'd4) ? 32'hFFFF_FFFF
                                         : ((32'd1 << (32'(out_nbytes) * 8)) - 32'd1);
    end

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_nbytes));

    // R8
    nbytes_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_nbytes >= 3'd1 && out_nbytes <= 3'd4));

    // R8
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & ~keep_mask) == 32'd0));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // R1
    refill_block_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !in_ready && !done);

    // R9
    err_empty_chk: assert property (@(posedge clk) disable iff (rst)
        done && done_err |-> done_bytes == '0);
endmodule

bind lzss_window_decoder lzss_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_nbytes (out_nbytes),
    .done       (done),
    .done_bytes (done_bytes),
    .done_err   (done_err)
);

// File: tb/lzss_window_decoder_bench.sv
module lzss_window_decoder_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = 20;
    localparam int NV    = 6;
    localparam int MAXB  = 24;

    localparam logic [7:0] V_IN [NV][MAXB] = '{
        '{8'hFF,8'h11,8'h12,8'h13,8'h14,8'h15,8'h16,8'h17,8'h18,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0},
        '{8'h00,8'h00,8'h00,8'h10,8'hF3,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0},
        '{8'h01,8'hAB,8'hEE,8'hF4,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0},
        '{8'hFF,8'h01,8'h02,8'h03,8'h04,8'h05,8'h06,8'h07,8'h08,
          8'hFF,8'h09,8'h0A,8'h0B,8'h0C,8'h0D,8'h0E,8'h0F,8'h10,
          8'h03,8'h11,8'h12,8'hFE,8'hF2,0},
        '{8'h02,8'h00,8'h0F,8'h5A,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0},
        '{8'h01,8'h77,8'h33,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0}
    };
    localparam int V_IN_N [NV] = '{9, 5, 4, 23, 4, 3};

    localparam logic [7:0] V_OUT [NV][MAXB] = '{
        '{8'h11,8'h12,8'h13,8'h14,8'h15,8'h16,8'h17,8'h18,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0},
        '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0},
        '{8'hAB,8'hAB,8'hAB,8'hAB,8'hAB,8'hAB,8'hAB,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0},
        '{8'h01,8'h02,8'h03,8'h04,8'h05,8'h06,8'h07,8'h08,8'h09,8'h0A,8'h0B,8'h0C,
          8'h0D,8'h0E,8'h0F,8'h10,8'h11,8'h12,8'h11,8'h12,8'h11,8'h12,0,0},
        '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,8'h5A,0,0,0,0,0,0},
        '{8'h77,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0}
    };
    localparam int V_OUT_N [NV] = '{8, 7, 7, 22, 18, 1};

    function automatic string vec_req(input int v);
        case (v)
            0: return "R2";
            1: return "R1/R3/R7";
            2: return "R4/R5";
            3: return "R6";
            4: return "R3";
            default: return "R7";
        endcase
    endfunction

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_data = '0;
    logic             in_last = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [31:0]      out_data;
    logic [2:0]       out_nbytes;
    logic             done;
    logic [CNT_W-1:0] done_bytes;
    logic             done_err;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] stim [64];
    int         stim_n;
    logic [7:0] got  [64];
    int         got_n;
    int         last_nb;
    int         pad_bad;
    int         got_cnt;
    logic       got_err;

    always #2.5 clk = ~clk;

    lzss_window_decoder #(.HDR_CHECK(1'b1), .CNT_W(CNT_W)) u_lzss_window_decoder (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_last    (in_last),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_nbytes (out_nbytes),
        .done       (done),
        .done_bytes (done_bytes),
        .done_err   (done_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build(input int v, input bit bad_sig, input int cut);
        logic [7:0] hdr [14];
        hdr = '{8'h53,8'h4C,8'h49,8'h44,8'h45,8'h34,8'h4B,8'h00,
                8'h00,8'h12,8'h00,8'h34,8'h56,8'h78};
        if (bad_sig) hdr[5] = 8'h38;
        stim_n = 0;
        for (int i = 0; i < ((cut > 0) ? cut : 14); i++) begin
            stim[stim_n] = hdr[i];
            stim_n++;
        end
        if (cut == 0 && v >= 0) begin
            for (int i = 0; i < V_IN_N[v]; i++) begin
                stim[stim_n] = V_IN[v][i];
                stim_n++;
            end
        end
    endtask

    task automatic play(input bit bp);
        int  idx;
        int  cyc;
        bit  fin;
        idx = 0; cyc = 0; fin = 1'b0;
        got_n = 0; last_nb = 0; pad_bad = 0; got_cnt = -1; got_err = 1'b0;
        while (!fin) begin
            @(negedge clk);
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            in_valid  = (idx < stim_n) && (!bp || (cyc % 4) != 2);
            in_data   = (idx < stim_n) ? stim[idx] : 8'h00;
            in_last   = (idx == stim_n - 1);
            #1;
            if (in_valid && in_ready) idx++;
            if (out_valid && out_ready) begin
                for (int k = 0; k < 4; k++) begin
                    if (k < int'(out_nbytes)) begin
                        if (got_n < 64) got[got_n] = out_data[8*k +: 8];
                        got_n++;
                    end else if (out_data[8*k +: 8] != 8'h00) begin
                        pad_bad++;
                    end
                end
                last_nb = int'(out_nbytes);
            end
            if (done) begin
                fin     = 1'b1;
                got_cnt = int'(done_bytes);
                got_err = done_err;
            end
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "R11", "watchdog: no done pulse", cyc, 20000);
                fin = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        out_ready = 1'b1;
        #1;
        // R1: window refill blocks input right after done
        check(!in_ready, "R1", "in_ready after done", in_ready, 0);
    endtask

    task automatic run_vec(input int v, input bit bp);
        int exp_nb;
        build(v, 1'b0, 0);
        play(bp);
        check(got_cnt == V_OUT_N[v], "R11", "done_bytes", got_cnt, V_OUT_N[v]);
        check(got_n == V_OUT_N[v], "R10", "bytes received", got_n, V_OUT_N[v]);
        for (int i = 0; i < V_OUT_N[v] && i < got_n; i++)
            check(got[i] == V_OUT[v][i], vec_req(v), $sformatf("byte %0d", i),
                  got[i], V_OUT[v][i]);
        exp_nb = (V_OUT_N[v] % 4 == 0) ? 4 : V_OUT_N[v] % 4;
        check(last_nb == exp_nb, "R8", "final word byte count", last_nb, exp_nb);
        check(pad_bad == 0, "R8", "nonzero padding", pad_bad, 0);
        check(got_err == 1'b0, "R9", "error on valid header", got_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(!in_ready, "R1", "in_ready after reset", in_ready, 0);
        check(!out_valid, "R8", "out_valid after reset", out_valid, 0);
        check(!done, "R11", "done after reset", done, 0);
        repeat (4070) @(negedge clk);
        #1;
        check(!in_ready, "R1", "in_ready during clear", in_ready, 0);
        repeat (20) @(negedge clk);
        #1;
        check(in_ready, "R1", "in_ready after clear", in_ready, 1);

        for (int v = 0; v < NV; v++) run_vec(v, 1'b0);
        for (int v = 0; v < NV; v++) run_vec(v, 1'b1);

        // R9: bad signature, payload must be swallowed
        build(0, 1'b1, 0);
        play(1'b0);
        check(got_err == 1'b1, "R9", "error on bad signature", got_err, 1);
        check(got_cnt == 0, "R9", "count on bad signature", got_cnt, 0);
        check(got_n == 0, "R9", "words on bad signature", got_n, 0);

        // R9: stream ends inside the header
        build(-1, 1'b0, 5);
        play(1'b0);
        check(got_err == 1'b1, "R9", "error on short header", got_err, 1);
        check(got_n == 0, "R9", "words on short header", got_n, 0);

        // R7: header only, empty payload
        build(-1, 1'b0, 0);
        play(1'b0);
        check(got_err == 1'b0, "R7", "error on empty payload", got_err, 0);
        check(got_cnt == 0, "R7", "count on empty payload", got_cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R11 global watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule